// File: doc/BRIEF.md
# Interrupt Running-Priority Tracker

This block holds, for a single processor interface of an interrupt controller, the identifier of the interrupt now in service and the priority at which that service runs. When the interface accepts a new interrupt, a set strobe arrives with the interrupt's identifier, its 8-bit priority and its group membership. The block keeps only the group-priority part of that priority and stores it as the running priority.

The group-priority part is the priority with its low bits cleared. The number of bits cleared is one more than a binary point value. Two binary point values come in as inputs: a normal one and an aliased one. Three inputs decide which of the two applies: whether grouping is supported, a control bit that asks for a common binary point, and the interrupt's group.

Loading the reserved identifier 1023 returns the interface to idle. In that case the running priority becomes 0x100, which is above every real priority. A combinational preempt output compares a candidate group priority against the stored running priority. A one-cycle update pulse tells the signalling logic to evaluate its outputs again after each load.

Top module: `rpt_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `run_id` is 1023, `run_prio` is 0x100, `idle` is 1 and `upd_pulse` is 0.
- R2: For a non-reserved identifier, the stored running priority is `set_prio` with bits [k:0] cleared, where k is the selected binary point (0..7). Binary point 0 keeps bits [7:1] and binary point 1 keeps bits [7:2]. Bit 8 of `run_prio` is then 0.
- R3: When the selected binary point is 7, the stored running priority is 0 for any `set_prio`.
- R4: Only bits [2:0] of the selected binary point input are used. Bit 3 has no effect on `run_prio`.
- R5: `bp_alias` is selected only when `groups_en`=1, `cbp_en`=0 and `set_grp1`=1 all hold. In every other combination, `bp_norm` is selected.
- R6: Loading identifier 1023 sets `run_prio` to 0x100 and `idle` to 1, whatever the priority, group and binary point inputs are.
- R7: `run_id` and `run_prio` load together on the rising edge where `set_valid` is 1, and the new values are visible in the next cycle. While `set_valid` is 0, both hold their values.
- R8: `upd_pulse` is 1 for exactly the cycle that follows each edge on which `set_valid` was 1, and is 0 otherwise.
- R9: `preempt` is 1 exactly when the 8-bit `cand_prio`, zero-extended to 9 bits, is strictly less than `run_prio`. In particular, it is always 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Strobe: load a new running interrupt |
| set_id | input | 10 | Identifier of the interrupt becoming active (1023 = none) |
| set_prio | input | 8 | Full priority of that interrupt |
| set_grp1 | input | 1 | Interrupt belongs to group 1 for this interface |
| groups_en | input | 1 | Interrupt grouping is supported |
| cbp_en | input | 1 | Use the common (normal) binary point for both groups |
| bp_norm | input | 4 | Normal binary point; bits [2:0] used |
| bp_alias | input | 4 | Aliased binary point; bits [2:0] used |
| cand_prio | input | 8 | Candidate group priority for the preemption compare |
| run_id | output | 10 | Identifier of the running interrupt |
| run_prio | output | 9 | Running priority (0x100 when idle) |
| idle | output | 1 | Running identifier is 1023 |
| preempt | output | 1 | Candidate priority is strictly below the running priority |
| upd_pulse | output | 1 | One-cycle request to evaluate signalling again |

## Verification
The bench builds the block with its default widths: an 8-bit priority, 10-bit identifiers and 4-bit binary point inputs that carry one unused top bit. With these widths, every binary point from 0 to 7 can be reached, along with the all-cleared case at 7. The ignored top bit can be driven high, and the idle value 0x100 sits one step above the largest real priority. As a result, `cand_prio` = 0xFF exercises the strict comparison against both the idle value and a running priority of 0xFE.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {
    BP_SRC_NORMAL = 1'b0,
    BP_SRC_ALIAS  = 1'b1
  } bp_src_e;
endpackage

// File: rtl/rpt_bp_select.sv
module rpt_bp_select #(
  parameter int BPIN_W = 4
) (
  input  logic              groups_en,
  input  logic              cbp_en,
  input  logic              grp1,
  input  logic [BPIN_W-1:0] bp_norm,
  input  logic [BPIN_W-1:0] bp_alias,
  output logic [BPIN_W-1:0] bp_sel
);
  import rpt_pkg::*;

  bp_src_e src;

  // The aliased point applies only to group 1 with banked points in use.
  always_comb begin
    if (groups_en && !cbp_en && grp1) src = BP_SRC_ALIAS;
    else                              src = BP_SRC_NORMAL;
  end

  always_comb begin
    bp_sel = (src == BP_SRC_ALIAS) ? bp_alias : bp_norm;
  end

  always_comb begin
    if (!groups_en || cbp_en || !grp1)
      AST_NORMAL_WHEN_NOT_ALL: assert (bp_sel == bp_norm); // R5
  end
endmodule

// File: rtl/rpt_group_mask.sv
module rpt_group_mask #(
  parameter int PRIO_W = 8,
  parameter int BPIN_W = 4
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic [BPIN_W-1:0] bp,
  output logic [PRIO_W-1:0] grp_prio
);
  localparam int SEL_W = $clog2(PRIO_W);

  logic [SEL_W-1:0]  bp_use;
  logic [PRIO_W-1:0] keep;

  assign bp_use = bp[SEL_W-1:0];

  // Bit i survives only when it lies above the binary point.
  for (genvar i = 0; i < PRIO_W; i++) begin : g_keep
    assign keep[i] = (i > int'(bp_use));
  end

  assign grp_prio = prio & keep;

  always_comb begin
    if (&bp_use)
      AST_TOP_POINT_ZERO: assert (grp_prio == '0); // R3
    AST_LSB_CLEAR: assert (grp_prio[0] == 1'b0); // R2
  end
endmodule

// File: rtl/rpt_run_reg.sv
module rpt_run_reg #(
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10,
  parameter int IDLE_ID = 1023
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ID_W-1:0] id_in,
  input  logic [PRIO_W-1:0] grp_prio,
  output logic [ID_W-1:0] run_id,
  output logic [PRIO_W:0] run_prio,
  output logic            upd
);
  localparam logic [ID_W-1:0] IDLE_ID_V   = ID_W'(IDLE_ID);
  localparam logic [PRIO_W:0] IDLE_PRIO_V = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W:0] next_prio;

  always_comb begin
    if (id_in == IDLE_ID_V) next_prio = IDLE_PRIO_V;
    else                    next_prio = {1'b0, grp_prio};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_id   <= IDLE_ID_V;
      run_prio <= IDLE_PRIO_V;
      upd      <= 1'b0;
    end else begin
      upd <= load;
      if (load) begin
        run_id   <= id_in;
        run_prio <= next_prio;
      end
    end
  end

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (rst)
    (run_id == IDLE_ID_V) |-> (run_prio == IDLE_PRIO_V)); // R6
  AST_REAL_BELOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (run_id != IDLE_ID_V) |-> (run_prio[PRIO_W] == 1'b0)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(run_id) && $stable(run_prio))); // R7
  AST_UPD_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> upd); // R8
  AST_UPD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !load |=> !upd); // R8
endmodule

// File: rtl/rpt_preempt_cmp.sv
module rpt_preempt_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand,
  input  logic [PRIO_W:0]   running,
  output logic              preempt
);
  assign preempt = ({1'b0, cand} < running);

  always_comb begin
    if (running[PRIO_W])
      AST_IDLE_ALWAYS_PREEMPT: assert (preempt); // R9
  end
endmodule

// File: rtl/rpt_tracker.sv
module rpt_tracker #(
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10,
  parameter int BPIN_W  = 4,
  parameter int IDLE_ID = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_valid,
  input  logic [ID_W-1:0]   set_id,
  input  logic [PRIO_W-1:0] set_prio,
  input  logic              set_grp1,
  input  logic              groups_en,
  input  logic              cbp_en,
  input  logic [BPIN_W-1:0] bp_norm,
  input  logic [BPIN_W-1:0] bp_alias,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic [ID_W-1:0]   run_id,
  output logic [PRIO_W:0]   run_prio,
  output logic              idle,
  output logic              preempt,
  output logic              upd_pulse
);
  localparam logic [ID_W-1:0] IDLE_ID_V = ID_W'(IDLE_ID);

  logic [BPIN_W-1:0] bp_sel;
  logic [PRIO_W-1:0] grp_prio;

  rpt_bp_select #(.BPIN_W(BPIN_W)) u_sel (
    .groups_en (groups_en),
    .cbp_en    (cbp_en),
    .grp1      (set_grp1),
    .bp_norm   (bp_norm),
    .bp_alias  (bp_alias),
    .bp_sel    (bp_sel)
  );

  rpt_group_mask #(.PRIO_W(PRIO_W), .BPIN_W(BPIN_W)) u_mask (
    .prio     (set_prio),
    .bp       (bp_sel),
    .grp_prio (grp_prio)
  );

  rpt_run_reg #(.PRIO_W(PRIO_W), .ID_W(ID_W), .IDLE_ID(IDLE_ID)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .load     (set_valid),
    .id_in    (set_id),
    .grp_prio (grp_prio),
    .run_id   (run_id),
    .run_prio (run_prio),
    .upd      (upd_pulse)
  );

  rpt_preempt_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .cand    (cand_prio),
    .running (run_prio),
    .preempt (preempt)
  );

  assign idle = (run_id == IDLE_ID_V);

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_id == IDLE_ID_V) |=> idle); // R6
  AST_LOAD_ID: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> (run_id == $past(set_id))); // R7
endmodule

// File: tb/rpt_tracker_tb.sv
module rpt_tracker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       set_valid = 1'b0;
  logic [9:0] set_id = '0;
  logic [7:0] set_prio = '0;
  logic       set_grp1 = 1'b0;
  logic       groups_en = 1'b0;
  logic       cbp_en = 1'b0;
  logic [3:0] bp_norm = '0;
  logic [3:0] bp_alias = '0;
  logic [7:0] cand_prio = '0;
  logic [9:0] run_id;
  logic [8:0] run_prio;
  logic       idle;
  logic       preempt;
  logic       upd_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rpt_tracker u_dut (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_id(set_id),
    .set_prio(set_prio), .set_grp1(set_grp1), .groups_en(groups_en),
    .cbp_en(cbp_en), .bp_norm(bp_norm), .bp_alias(bp_alias),
    .cand_prio(cand_prio), .run_id(run_id), .run_prio(run_prio),
    .idle(idle), .preempt(preempt), .upd_pulse(upd_pulse)
  );

  function automatic logic [7:0] gp(input logic [7:0] p, input logic [3:0] bp);
    logic [15:0] m;
    m = 16'h00FF << (int'(bp[2:0]) + 1);
    return p & m[7:0];
  endfunction

  function automatic logic [3:0] pick(input logic ge, input logic cb,
                                      input logic g1, input logic [3:0] n,
                                      input logic [3:0] a);
    return (ge && !cb && g1) ? a : n;
  endfunction

  function automatic logic [8:0] exp_run(input logic [9:0] id, input logic [7:0] p,
                                         input logic ge, input logic cb, input logic g1,
                                         input logic [3:0] n, input logic [3:0] a);
    if (id == 10'd1023) return 9'h100;
    return {1'b0, gp(p, pick(ge, cb, g1, n, a))};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one load, then check both registers and the update pulse.
  task automatic load(input string req, input logic [9:0] id, input logic [7:0] p,
                      input logic ge, input logic cb, input logic g1,
                      input logic [3:0] n, input logic [3:0] a);
    logic [8:0] e;
    @(negedge clk);
    set_valid = 1'b1; set_id = id; set_prio = p; groups_en = ge;
    cbp_en = cb; set_grp1 = g1; bp_norm = n; bp_alias = a;
    e = exp_run(id, p, ge, cb, g1, n, a);
    @(negedge clk);
    set_valid = 1'b0;
    chk(req, int'(run_prio), int'(e));
    chk({req, "/R7 id"}, int'(run_id), int'(id));
    chk("R8 pulse high", int'(upd_pulse), 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 id", int'(run_id), 1023);
    chk("R1 prio", int'(run_prio), 'h100);
    chk("R1 idle", int'(idle), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release prio", int'(run_prio), 'h100);
    chk("R1 upd", int'(upd_pulse), 0);

    // R2/R3 every binary point with all priority bits set
    for (int b = 0; b < 8; b++)
      load(b == 7 ? "R3 bp7" : "R2 mask", 10'd5, 8'hFF, 1'b0, 1'b0, 1'b0, 4'(b), 4'h0);
    load("R3 zero", 10'd6, 8'hA5, 1'b0, 1'b0, 1'b0, 4'd7, 4'd0);
    // R4 top bit ignored
    load("R4 hi bit", 10'd7, 8'hFF, 1'b0, 1'b0, 1'b0, 4'b1010, 4'd0);
    chk("R4 value", int'(run_prio), 'hF8);
    // R5 all eight select combinations
    for (int c = 0; c < 8; c++)
      load("R5 select", 10'd9, 8'hFF, c[2], c[1], c[0], 4'd0, 4'd5);
    // R6 idle load overrides priority
    load("R6 idle", 10'd1023, 8'h00, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0);
    chk("R6 idle flag", int'(idle), 1);
    // R9 idle always preempts
    cand_prio = 8'hFF; #1;
    chk("R9 idle preempt", int'(preempt), 1);
    // R7 hold and R8 pulse clear
    load("R2 load", 10'd40, 8'hFE, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0);
    held = run_prio;
    @(negedge clk);
    set_prio = 8'h00; set_id = 10'd3;
    @(negedge clk);
    chk("R7 hold prio", int'(run_prio), int'(held));
    chk("R7 hold id", int'(run_id), 40);
    chk("R8 pulse low", int'(upd_pulse), 0);
    // R9 strict compare around 0xFE
    cand_prio = 8'hFE; #1;
    chk("R9 equal", int'(preempt), 0);
    cand_prio = 8'hFD; #1;
    chk("R9 below", int'(preempt), 1);
    cand_prio = 8'hFF; #1;
    chk("R9 above", int'(preempt), 0);

    // Random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      logic [9:0] id;
      logic [7:0] cp;
      id = ($urandom % 8 == 0) ? 10'd1023 : 10'($urandom % 1023);
      load("R2/R5 random", id, 8'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 4'($urandom), 4'($urandom));
      cp = 8'($urandom);
      cand_prio = cp; #1;
      chk("R9 random", int'(preempt), int'({1'b0, cp} < run_prio));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule